// File: doc/BRIEF.md
# Two-Channel Programmable Timer

This peripheral holds a pair of independent 32-bit counting channels. Each channel has three words on a single-cycle register bus: a control/status word, a load word and a read-only live count. A channel counts one step per clock, up or down, while its run bit is set. A software-pulsed load bit copies the load word into the count. An expiry raises a sticky event flag, and software clears that flag by writing a one to it.

Software uses a down-counting channel with reload as a periodic tick source, and the same channel without reload as a one-shot delay. An up-counting channel with reload runs free and serves as a wrapping time base that can be read at any moment. A single interrupt line combines the flags of the channels whose interrupt enable is set.

Writes take effect on the clock edge. Reads are combinational from the address and have no side effects.

Top module: `duo_timer`

## Requirements
- R1: After reset every control word, load word and count reads 0, and `irq_o` is low.
- R2: Each channel owns a 16-byte window. Channel 0 sits at byte 0x00 and channel 1 at byte 0x10. Within a window, offset 0x0 is control, offset 0x4 is load and offset 0x8 is count. Writes to the count word are ignored. Control bits 10:0 read back as written, apart from the flag at bit 8. Bits 0, 2, 3, 9 and 10 are stored but have no effect on counting or on the interrupt.
- R3: Control bit 5 is the load bit. While the stored load bit is 1, the count takes the load word on every edge and does not step.
- R4: The run bit is bit 7 and the direction bit is bit 1, where 1 means down. While the channel runs and has not stopped, the count falls by one per clock when down is selected and rises by one per clock otherwise.
- R5: An up count that steps past all-ones while the reload bit (bit 4) is set wraps to 0 and keeps counting.
- R6: A down count that steps past 0 while the reload bit is set takes the load word on that edge and keeps counting.
- R7: When the reload bit is clear, an expiry leaves the count unchanged (0 for a down count, all-ones for an up count). The channel then stays stopped until the load bit is applied or the run bit is cleared.
- R8: Clearing the run bit freezes the count at its current value.
- R9: Every expiry sets the flag (bit 8) on the same edge. Writing 1 to bit 8 clears the flag and writing 0 leaves it unchanged. If an expiry and a clearing write fall on the same edge, the flag ends up set.
- R10: `irq_o` is the OR, over both channels, of the flag ANDed with the interrupt-enable bit (bit 6).
- R11: Neither channel's registers, counting or flag are affected by traffic or events on the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write lands on the next rising edge |
| bus_addr | input | 5 | Byte address of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The count is exercised under five patterns:
- a down one-shot from a small load value, which shows whether the channel stops at expiry or wraps;
- a periodic down run over several periods, which shows whether the reload value is used instead of the all-ones wrap;
- an up free-run preloaded just below the top, which exposes the all-ones to 0 wrap and the flag it raises;
- a one-shot up run, which shows whether the channel holds at all-ones;
- a halted channel, which shows whether the count holds.

The flag is acknowledged by writing back the control word as read. One of these writes is timed onto the exact edge of an expiry, to tell apart set-wins from clear-wins. Unimplemented control bits are written while the count and interrupt are observed, which separates stored-only bits from bits that act.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

  localparam int CSR_W  = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_ARL  = 4;
  localparam int B_LOAD = 5;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;

  function automatic logic [31:0] step_val(input logic [31:0] v, input logic down);
    return down ? v - 32'd1 : v + 32'd1;
  endfunction

  function automatic logic at_edge(input logic [31:0] v, input logic down);
    return down ? (v == 32'd0) : (v == 32'hFFFF_FFFF);
  endfunction

endpackage

// File: rtl/duo_timer_chan.sv
module duo_timer_chan
  import duo_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             load_wr,
  input  logic [31:0]      wdata,
  output logic [CSR_W-1:0] ctrl_o,
  output logic [31:0]      load_o,
  output logic [31:0]      cnt_o,
  output logic             req_o,
  output logic             flag_o
);

  logic [CSR_W-1:0] ctrl_q, ctrl_d;
  logic [31:0]      load_q, cnt_q, cnt_d;
  logic             stop_q, stop_d;
  logic             down, arl, ld, run, flag, ie;
  logic             counting, at_lim, expire, flag_clr, flag_d;

  assign down = ctrl_q[B_DOWN];
  assign arl  = ctrl_q[B_ARL];
  assign ld   = ctrl_q[B_LOAD];
  assign run  = ctrl_q[B_RUN];
  assign flag = ctrl_q[B_FLAG];
  assign ie   = ctrl_q[B_IE];

  assign counting = run && !ld && !stop_q;
  assign at_lim   = at_edge(cnt_q, down);
  assign expire   = counting && at_lim;
  assign flag_clr = ctrl_wr && wdata[B_FLAG];
  assign flag_d   = expire || (flag && !flag_clr);

  always_comb begin
    cnt_d = cnt_q;
    if (ld) begin
      cnt_d = load_q;
    end else if (counting) begin
      if (!at_lim)       cnt_d = step_val(cnt_q, down);
      else if (arl)      cnt_d = down ? load_q : step_val(cnt_q, down);
    end
  end

  always_comb begin
    stop_d = stop_q;
    if (ld || !run)            stop_d = 1'b0;
    else if (expire && !arl)   stop_d = 1'b1;
  end

  always_comb begin
    ctrl_d = ctrl_wr ? wdata[CSR_W-1:0] : ctrl_q;
    ctrl_d[B_FLAG] = flag_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      stop_q <= stop_d;
      if (load_wr) load_q <= wdata;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign req_o  = flag && ie;
  assign flag_o = flag;

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(load_q));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && down && cnt_q != 32'd0) |=> cnt_q == $past(cnt_q) - 32'd1);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && arl && down) |=> cnt_q == $past(load_q));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt_q));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl_q[B_FLAG]);

endmodule

// File: rtl/duo_timer_irq.sv
module duo_timer_irq #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              irq_o
);
  assign irq_o = |req_i;
endmodule

// File: rtl/duo_timer.sv
module duo_timer
  import duo_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_BITS + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);

  logic [CSR_W-1:0] ctrl_v [NUM_CH];
  logic [31:0]      load_v [NUM_CH];
  logic [31:0]      cnt_v  [NUM_CH];
  logic [NUM_CH-1:0] req_v, flag_v;
  word_sel_e        sel;
  logic [CH_BITS-1:0] ch_idx;

  assign sel    = word_sel_e'(bus_addr[3:2]);
  assign ch_idx = bus_addr[ADDR_W-1:4];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (ch_idx == CH_BITS'(c));
    duo_timer_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (hit && sel == SEL_CTRL),
      .load_wr (hit && sel == SEL_LOAD),
      .wdata   (bus_wdata),
      .ctrl_o  (ctrl_v[c]),
      .load_o  (load_v[c]),
      .cnt_o   (cnt_v[c]),
      .req_o   (req_v[c]),
      .flag_o  (flag_v[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(ch_idx) < NUM_CH) begin
      case (sel)
        SEL_CTRL: bus_rdata = 32'(ctrl_v[ch_idx]);
        SEL_LOAD: bus_rdata = load_v[ch_idx];
        SEL_CNT:  bus_rdata = cnt_v[ch_idx];
        default:  bus_rdata = '0;
      endcase
    end
  end

  duo_timer_irq #(.NUM_CH(NUM_CH)) u_irq (
    .req_i (req_v),
    .irq_o (irq_o)
  );

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_v != '0));

endmodule

// File: tb/duo_timer_bench.sv
`timescale 1ns/1ps
module duo_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  duo_timer u_duo_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference state
  logic [10:0] m_ctrl [2];
  logic [31:0] m_load [2];
  logic [31:0] m_cnt  [2];
  bit          m_stop [2];

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = '0; m_load[c] = '0; m_cnt[c] = '0; m_stop[c] = 0;
    end
  endtask

  task automatic m_edge(input bit we, input logic [4:0] a, input logic [31:0] d);
    for (int c = 0; c < 2; c++) begin
      bit mine, dn, rl, pre, go, lim, hit, clr;
      logic [31:0] nc;
      mine = we && (a[4] == c[0]);
      dn = m_ctrl[c][1]; rl = m_ctrl[c][4]; pre = m_ctrl[c][5]; go = m_ctrl[c][7];
      hit = 0; nc = m_cnt[c];
      if (pre) nc = m_load[c];
      else if (go && !m_stop[c]) begin
        lim = dn ? (m_cnt[c] == 0) : (m_cnt[c] == 32'hFFFF_FFFF);
        if (!lim) nc = dn ? m_cnt[c] - 1 : m_cnt[c] + 1;
        else begin
          hit = 1;
          if (rl) nc = dn ? m_load[c] : 32'd0;
        end
      end
      if (pre || !go) m_stop[c] = 0;
      else if (hit && !rl) m_stop[c] = 1;
      clr = mine && a[3:2] == 2'd0 && d[8];
      begin
        bit f;
        f = hit || (m_ctrl[c][8] && !clr);
        if (mine && a[3:2] == 2'd0) m_ctrl[c] = d[10:0];
        m_ctrl[c][8] = f;
      end
      if (mine && a[3:2] == 2'd1) m_load[c] = d;
      m_cnt[c] = nc;
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a[3:2])
      2'd0: return 32'(m_ctrl[a[4]]);
      2'd1: return m_load[a[4]];
      2'd2: return m_cnt[a[4]];
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit m_irq();
    return (m_ctrl[0][8] && m_ctrl[0][6]) || (m_ctrl[1][8] && m_ctrl[1][6]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [4:0] a);
    bus_addr = a;
    #0.2;
    check(req, bus_rdata, m_read(a));
  endtask

  // one clock with an optional write, then compare counts and irq
  task automatic cyc(input bit we, input logic [4:0] a, input logic [31:0] d, input string req);
    bus_wr = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    m_edge(we, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " irq"}, 32'(irq_o), 32'(m_irq()));
    peek({req, " cnt0"}, 5'h08);
    peek({req, " cnt1"}, 5'h18);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 5'h00, 32'd0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'd0);
    foreach (m_ctrl[i]) begin end
    peek("R1", 5'h00); peek("R1", 5'h04); peek("R1", 5'h08);
    peek("R1", 5'h10); peek("R1", 5'h14); peek("R1", 5'h18);

    // R2 stored-only bits read back and have no effect
    cyc(1, 5'h00, 32'h0000_060D, "R2");
    idle(3, "R2");
    peek("R2 ctrl0", 5'h00);
    cyc(1, 5'h08, 32'h1234_5678, "R2 cnt write ignored");
    peek("R2 cnt0", 5'h08);
    cyc(1, 5'h00, 32'd0, "R2");

    // R3 load bit, then R4/R7 down one-shot with interrupt (R10)
    cyc(1, 5'h04, 32'd5, "R3");
    peek("R3 load0", 5'h04);
    cyc(1, 5'h00, 32'h0000_0020, "R3");
    cyc(0, 5'h00, 32'd0, "R3");
    cyc(1, 5'h00, 32'h0000_00C2, "R4");
    idle(9, "R7 down one-shot");
    // R9 writing zero to the flag leaves it set
    cyc(1, 5'h00, 32'h0000_00C2, "R9 write zero");
    peek("R9 flag kept", 5'h00);
    // R9 acknowledge by writing back what was read
    bus_addr = 5'h00; #0.2;
    cyc(1, 5'h00, bus_rdata, "R9 ack");
    peek("R9 flag cleared", 5'h00);

    // R6 periodic down with reload
    cyc(1, 5'h04, 32'd3, "R6");
    cyc(1, 5'h00, 32'h0000_0020, "R6");
    cyc(1, 5'h00, 32'h0000_00D2, "R6");
    idle(12, "R6 periodic");
    // R9 clearing write on the edge of an expiry: set wins
    begin
      int guard = 0;
      while (m_cnt[0] != 0 && guard < 20) begin idle(1, "R9"); guard++; end
    end
    cyc(1, 5'h00, 32'h0000_01D2, "R9 set wins");
    peek("R9 set wins ctrl0", 5'h00);
    cyc(1, 5'h00, 32'h0000_01D2, "R9 clear");

    // R8 halt
    idle(2, "R8");
    cyc(1, 5'h00, 32'h0000_0052, "R8 halt");
    idle(5, "R8 hold");

    // R5/R11 channel 1 up free-run with wrap
    cyc(1, 5'h14, 32'hFFFF_FFFD, "R11");
    cyc(1, 5'h10, 32'h0000_0020, "R11");
    cyc(1, 5'h10, 32'h0000_00D0, "R5");
    idle(6, "R5 wrap");
    peek("R11 ctrl0", 5'h00); peek("R11 ctrl1", 5'h10); peek("R11 load0", 5'h04);

    // R7 up one-shot holds at all-ones, interrupt disabled (R10)
    cyc(1, 5'h10, 32'h0000_0100, "R7");
    cyc(1, 5'h14, 32'hFFFF_FFFE, "R7");
    cyc(1, 5'h10, 32'h0000_0020, "R7");
    cyc(1, 5'h10, 32'h0000_0080, "R7 up");
    idle(5, "R7 up hold");
    peek("R10 flag1 without enable", 5'h10);
    check("R10 masked irq", 32'(irq_o), 32'(m_irq()));
    // R7 clearing run then restarting expires again from all-ones
    cyc(1, 5'h10, 32'h0000_0000, "R7");
    cyc(1, 5'h10, 32'h0000_00C0, "R7 restart");
    idle(3, "R7 restart");

    finish_run();
  end

endmodule